// File: doc/BRIEF.md
# Multi-Mode Waveform Timer

The block is an 8-bit counter that advances on a count-enable tick and feeds two compare channels. Each channel compares the running count against its own compare value. On a match it raises a sticky flag and drives a waveform pin. A 3-bit mode field selects one of four counting schemes: plain free-running, clear-on-compare, single-slope fast PWM and dual-slope phase-correct PWM. The mode also decides where the counter turns (TOP is either the all-ones value or compare value A), when new compare values take effect, and at which count the overflow flag is raised.

Software may load the counter and the compare values at any time, set the per-channel output action, and pulse force strobes in the non-PWM modes. Each of the three flags stays set until software writes a one to its clear bit. Clock prescaling is done outside the block, which only sees the tick.

Top module: `wavetimer8`

## Requirements
- R1: After reset the count, both active compare values, both waveform pins and all three flags are zero, and the counter direction is up.
- R2: Mode codes: 000 normal (TOP 0xFF), 010 clear-on-compare (TOP = compare A), 011 fast PWM (TOP 0xFF) and 111 fast PWM (TOP = compare A). Codes 100 and 110 act as 000. In these modes a tick at TOP loads 0, and any other tick adds one.
- R3: Codes 001 (TOP 0xFF) and 101 (TOP = compare A) are phase-correct. The count rises to TOP, then falls to 0, then rises again. The turn at TOP and the turn at 0 each take one tick.
- R4: In normal and clear-on-compare modes a compare write takes effect at the next clock. In PWM modes a write goes to a shadow register. The shadow is copied to the active value on a tick with count equal to TOP (phase-correct) or equal to 0 (fast PWM). A write in the same cycle as the copy waits for the next copy point.
- R5: The overflow flag is set on a tick at count 0xFF in modes 000, 010 and 011. It is set on a tick at count 0 in both phase-correct modes, and on a tick at TOP in mode 111.
- R6: In non-PWM modes a match drives the pin according to the 2-bit output action: 00 gives a low output, 01 toggles, 10 clears and 11 sets.
- R7: In fast PWM, action 10 clears the pin on a match and sets it on a tick at count 0, and action 11 does the opposite. When both happen on one tick, the match wins. Actions 00 and 01 give a low output in all PWM modes.
- R8: In phase-correct PWM, action 10 clears the pin on a match while counting up and sets it on a match while counting down. Action 11 inverts both.
- R9: A force strobe applies its channel's action to the pin at the next clock, in non-PWM modes only. It never sets a flag.
- R10: A counter write blocks compare matches in the cycle that follows it, so a match on the written value is lost.
- R11: A match is a tick with the count equal to the channel's active value. The flags are sticky. The clear word's bit 0 clears compare A, bit 1 clears compare B and bit 2 clears overflow. A set and a clear in the same cycle leave the flag set.
- R12: A counter write takes precedence over the tick. With no tick and no write, the count and the direction hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable for this cycle |
| cnt_wr | input | 1 | Load the counter |
| cnt_wdata | input | 8 | Counter load value |
| cmpa_wr | input | 1 | Write compare value A |
| cmpa_wdata | input | 8 | Compare A write data |
| cmpb_wr | input | 1 | Write compare value B |
| cmpb_wdata | input | 8 | Compare B write data |
| mode | input | 3 | Counting mode code |
| outmode_a | input | 2 | Channel A output action |
| outmode_b | input | 2 | Channel B output action |
| force_a | input | 1 | Force strobe, channel A |
| force_b | input | 1 | Force strobe, channel B |
| flag_clr | input | 3 | Write-one-to-clear: bit0 A, bit1 B, bit2 overflow |
| count | output | 8 | Current counter value |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| flag_cmpa | output | 1 | Compare A flag |
| flag_cmpb | output | 1 | Compare B flag |
| flag_ovf | output | 1 | Overflow flag |

## Verification
The assertions assume that every input is driven to a known level from reset onward and changes only away from the active clock edge. The write-masking and sticky-flag properties look back one cycle, so they also assume the write strobes are low while reset is held. The stimulus changes all inputs on the falling edge. It holds every strobe low during reset, and when it changes mode it first reloads the counter so that the count starts below the new TOP.

// File: rtl/wavetimer8_pkg.sv
package wavetimer8_pkg;

   localparam int unsigned MODE_BITS = 3;

   typedef enum logic [1:0] {
      SEQ_NORMAL = 2'd0,
      SEQ_CTC    = 2'd1,
      SEQ_FAST   = 2'd2,
      SEQ_PHASE  = 2'd3
   } seq_e;

   typedef struct packed {
      seq_e seq;
      logic top_from_a;
   } mode_cfg_t;

   localparam logic [1:0] OM_OFF    = 2'b00;
   localparam logic [1:0] OM_TOGGLE = 2'b01;
   localparam logic [1:0] OM_CLEAR  = 2'b10;
   localparam logic [1:0] OM_SET    = 2'b11;

endpackage

// File: rtl/wt_mode_dec.sv
module wt_mode_dec
   import wavetimer8_pkg::*;
(
   input  logic [MODE_BITS-1:0] mode,
   output mode_cfg_t            cfg
);

   always_comb begin
      cfg.seq        = SEQ_NORMAL;
      cfg.top_from_a = 1'b0;
      unique case (mode)
         3'b001: cfg.seq = SEQ_PHASE;
         3'b010: begin cfg.seq = SEQ_CTC;   cfg.top_from_a = 1'b1; end
         3'b011: cfg.seq = SEQ_FAST;
         3'b101: begin cfg.seq = SEQ_PHASE; cfg.top_from_a = 1'b1; end
         3'b111: begin cfg.seq = SEQ_FAST;  cfg.top_from_a = 1'b1; end
         default: begin cfg.seq = SEQ_NORMAL; cfg.top_from_a = 1'b0; end
      endcase
   end

endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] top,
   input  logic         phase,
   output logic [W-1:0] count,
   output logic         dir_down,
   output logic         at_top,
   output logic         at_bottom
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] cnt_n;
   logic         dir_n;

   assign at_top    = (count == top);
   assign at_bottom = (count == '0);

   always_comb begin
      cnt_n = count;
      dir_n = dir_down;
      if (wr) begin
         cnt_n = wdata;
      end else if (tick) begin
         if (!phase) begin
            cnt_n = at_top ? '0 : count + 1'b1;
            dir_n = 1'b0;
         end else if (!dir_down) begin
            if (at_top) begin
               if (at_bottom) begin
                  cnt_n = '0;
               end else begin
                  cnt_n = count - 1'b1;
                  dir_n = 1'b1;
               end
            end else begin
               cnt_n = count + 1'b1;
            end
         end else begin
            if (at_bottom) begin
               cnt_n = at_top ? '0 : ONE;
               dir_n = 1'b0;
            end else begin
               cnt_n = count - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         dir_down <= 1'b0;
      end else begin
         count    <= cnt_n;
         dir_down <= dir_n;
      end
   end

   a_r2_wrap_at_top: assert property (@(posedge clk) disable iff (!rst_n)
      (!phase && tick && !wr && at_top) |=> (count == '0));

   a_r3_descend: assert property (@(posedge clk) disable iff (!rst_n)
      (phase && tick && !wr && dir_down && !at_bottom) |=> (count == $past(count) - 1'b1));

   a_r3_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
      (phase && tick && !wr && !dir_down && at_top && !at_bottom) |=> dir_down);

   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr) |=> ($stable(count) && $stable(dir_down)));

endmodule

// File: rtl/wt_channel.sv
module wt_channel
   import wavetimer8_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         sup,
   input  seq_e         seq,
   input  logic         dir_down,
   input  logic         at_bottom,
   input  logic [W-1:0] count,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         upd,
   input  logic [1:0]   om,
   input  logic         force_s,
   output logic [W-1:0] cmp_act,
   output logic         match,
   output logic         wave
);

   logic [W-1:0] cmp_shadow;
   logic         pin;
   logic         pin_n;
   logic         immediate;

   assign immediate = (seq == SEQ_NORMAL) || (seq == SEQ_CTC);
   assign match     = tick && !sup && (count == cmp_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_act    <= '0;
         cmp_shadow <= '0;
      end else if (immediate) begin
         if (wr) begin
            cmp_act    <= wdata;
            cmp_shadow <= wdata;
         end
      end else begin
         if (upd) cmp_act <= cmp_shadow;
         if (wr)  cmp_shadow <= wdata;
      end
   end

   always_comb begin
      pin_n = pin;
      unique case (seq)
         SEQ_FAST: begin
            if (match) begin
               if (om == OM_CLEAR)     pin_n = 1'b0;
               else if (om == OM_SET)  pin_n = 1'b1;
            end else if (tick && at_bottom) begin
               if (om == OM_CLEAR)     pin_n = 1'b1;
               else if (om == OM_SET)  pin_n = 1'b0;
            end
         end
         SEQ_PHASE: begin
            if (match) begin
               if (om == OM_CLEAR)     pin_n = dir_down;
               else if (om == OM_SET)  pin_n = !dir_down;
            end
         end
         default: begin
            if (match || force_s) begin
               unique case (om)
                  OM_TOGGLE: pin_n = !pin;
                  OM_CLEAR:  pin_n = 1'b0;
                  OM_SET:    pin_n = 1'b1;
                  default:   pin_n = pin;
               endcase
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin <= 1'b0;
      else        pin <= pin_n;
   end

   assign wave = pin && (immediate ? (om != OM_OFF) : om[1]);

   a_r9_force_only_nonpwm: assert property (@(posedge clk) disable iff (!rst_n)
      (!immediate && !match && !(tick && at_bottom)) |=> $stable(pin));

endmodule

// File: rtl/wavetimer8.sv
module wavetimer8
   import wavetimer8_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 cnt_wr,
   input  logic [W-1:0]         cnt_wdata,
   input  logic                 cmpa_wr,
   input  logic [W-1:0]         cmpa_wdata,
   input  logic                 cmpb_wr,
   input  logic [W-1:0]         cmpb_wdata,
   input  logic [MODE_BITS-1:0] mode,
   input  logic [1:0]           outmode_a,
   input  logic [1:0]           outmode_b,
   input  logic                 force_a,
   input  logic                 force_b,
   input  logic [2:0]           flag_clr,
   output logic [W-1:0]         count,
   output logic                 wave_a,
   output logic                 wave_b,
   output logic                 flag_cmpa,
   output logic                 flag_cmpb,
   output logic                 flag_ovf
);

   localparam int unsigned   NCH     = 2;
   localparam logic [W-1:0] CNT_MAX = '1;

   if (W < 2) begin : g_bad_width
      $error("wavetimer8: W must be at least 2");
   end

   mode_cfg_t    cfg;
   logic [W-1:0] top;
   logic         dir_down;
   logic         at_top;
   logic         at_bottom;
   logic         sup;
   logic         upd;
   logic         ovf_evt;

   logic [NCH-1:0][W-1:0] ch_wdata;
   logic [NCH-1:0][W-1:0] ch_act;
   logic [NCH-1:0][1:0]   ch_om;
   logic [NCH-1:0]        ch_wr;
   logic [NCH-1:0]        ch_force;
   logic [NCH-1:0]        ch_match;
   logic [NCH-1:0]        ch_wave;
   logic [NCH-1:0]        flag_cmp;

   assign ch_wr    = {cmpb_wr, cmpa_wr};
   assign ch_wdata = {cmpb_wdata, cmpa_wdata};
   assign ch_om    = {outmode_b, outmode_a};
   assign ch_force = {force_b, force_a};

   wt_mode_dec u_dec (
      .mode (mode),
      .cfg  (cfg)
   );

   assign top = cfg.top_from_a ? ch_act[0] : CNT_MAX;

   wt_counter #(.W(W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .wr        (cnt_wr),
      .wdata     (cnt_wdata),
      .top       (top),
      .phase     (cfg.seq == SEQ_PHASE),
      .count     (count),
      .dir_down  (dir_down),
      .at_top    (at_top),
      .at_bottom (at_bottom)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sup <= 1'b0;
      else        sup <= cnt_wr;
   end

   assign upd = tick && (((cfg.seq == SEQ_PHASE) && at_top) ||
                         ((cfg.seq == SEQ_FAST)  && at_bottom));

   always_comb begin
      unique case (cfg.seq)
         SEQ_PHASE: ovf_evt = tick && at_bottom;
         SEQ_FAST:  ovf_evt = tick && (cfg.top_from_a ? at_top : (count == CNT_MAX));
         default:   ovf_evt = tick && (count == CNT_MAX);
      endcase
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      wt_channel #(.W(W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .sup       (sup),
         .seq       (cfg.seq),
         .dir_down  (dir_down),
         .at_bottom (at_bottom),
         .count     (count),
         .wr        (ch_wr[i]),
         .wdata     (ch_wdata[i]),
         .upd       (upd),
         .om        (ch_om[i]),
         .force_s   (ch_force[i]),
         .cmp_act   (ch_act[i]),
         .match     (ch_match[i]),
         .wave      (ch_wave[i])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_cmp[i] <= 1'b0;
         else        flag_cmp[i] <= ch_match[i] || (flag_cmp[i] && !flag_clr[i]);
      end

      a_r4_immediate_write: assert property (@(posedge clk) disable iff (!rst_n)
         (((cfg.seq == SEQ_NORMAL) || (cfg.seq == SEQ_CTC)) && ch_wr[i])
         |=> (ch_act[i] == $past(ch_wdata[i])));

      a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
         (!upd && !(((cfg.seq == SEQ_NORMAL) || (cfg.seq == SEQ_CTC)) && ch_wr[i]))
         |=> $stable(ch_act[i]));

      a_r11_cmp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_cmp[i] && !flag_clr[i]) |=> flag_cmp[i]);

      a_r10_write_masks: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(cnt_wr) && !flag_cmp[i]) |=> !flag_cmp[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_ovf <= 1'b0;
      else        flag_ovf <= ovf_evt || (flag_ovf && !flag_clr[2]);
   end

   assign flag_cmpa = flag_cmp[0];
   assign flag_cmpb = flag_cmp[1];
   assign wave_a    = ch_wave[0];
   assign wave_b    = ch_wave[1];

   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> flag_ovf);

   a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_ovf && !flag_clr[2]) |=> flag_ovf);

endmodule

// File: tb/wavetimer8_tb.sv
module wavetimer8_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       cnt_wr = 1'b0;
   logic [7:0] cnt_wdata = '0;
   logic       cmpa_wr = 1'b0;
   logic [7:0] cmpa_wdata = '0;
   logic       cmpb_wr = 1'b0;
   logic [7:0] cmpb_wdata = '0;
   logic [2:0] mode = '0;
   logic [1:0] outmode_a = '0;
   logic [1:0] outmode_b = '0;
   logic       force_a = 1'b0;
   logic       force_b = 1'b0;
   logic [2:0] flag_clr = '0;
   logic [7:0] count;
   logic       wave_a, wave_b, flag_cmpa, flag_cmpb, flag_ovf;

   always #2 clk = ~clk;

   wavetimer8 u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .cmpa_wr(cmpa_wr), .cmpa_wdata(cmpa_wdata),
      .cmpb_wr(cmpb_wr), .cmpb_wdata(cmpb_wdata),
      .mode(mode), .outmode_a(outmode_a), .outmode_b(outmode_b),
      .force_a(force_a), .force_b(force_b), .flag_clr(flag_clr),
      .count(count), .wave_a(wave_a), .wave_b(wave_b),
      .flag_cmpa(flag_cmpa), .flag_cmpb(flag_cmpb), .flag_ovf(flag_ovf)
   );

   int    errs = 0;
   int    checks = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   int m_cnt, m_dn, m_actA, m_actB, m_bufA, m_bufB, m_pinA, m_pinB;
   int m_fA, m_fB, m_fO, m_sup;

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int seq_of(int m);
      case (m)
         1, 5:    return 3;
         2:       return 1;
         3, 7:    return 2;
         default: return 0;
      endcase
   endfunction

   function automatic int pin_next(int sq, int om, int p, int mt, int frc, int bot, int dn);
      if (sq < 2) begin
         if (mt != 0 || frc != 0) begin
            if (om == 1) return 1 - p;
            if (om == 2) return 0;
            if (om == 3) return 1;
         end
         return p;
      end
      if (sq == 2) begin
         if (mt != 0) begin
            if (om == 2) return 0;
            if (om == 3) return 1;
         end else if (bot != 0) begin
            if (om == 2) return 1;
            if (om == 3) return 0;
         end
         return p;
      end
      if (mt != 0) begin
         if (om == 2) return dn;
         if (om == 3) return 1 - dn;
      end
      return p;
   endfunction

   function automatic int wave_exp(int sq, int om, int p);
      if (om == 0) return 0;
      if (sq >= 2 && om == 1) return 0;
      return p;
   endfunction

   task automatic model_step();
      int sq, topa, top, at_t, at_b, ma, mb, ovf, upd, tk;
      int nA, nB;
      if (!rst_n) begin
         m_cnt = 0; m_dn = 0; m_actA = 0; m_actB = 0; m_bufA = 0; m_bufB = 0;
         m_pinA = 0; m_pinB = 0; m_fA = 0; m_fB = 0; m_fO = 0; m_sup = 0;
         return;
      end
      tk   = tick;
      sq   = seq_of(mode);
      topa = (mode == 2 || mode == 5 || mode == 7);
      top  = topa ? m_actA : 255;
      at_t = (m_cnt == top);
      at_b = (m_cnt == 0);
      ma   = tk && !m_sup && (m_cnt == m_actA);
      mb   = tk && !m_sup && (m_cnt == m_actB);
      if (sq == 3)              ovf = tk && at_b;
      else if (sq == 2 && topa) ovf = tk && at_t;
      else                      ovf = tk && (m_cnt == 255);
      upd  = tk && ((sq == 3 && at_t) || (sq == 2 && at_b));
      m_pinA = pin_next(sq, outmode_a, m_pinA, ma, force_a, tk && at_b, m_dn);
      m_pinB = pin_next(sq, outmode_b, m_pinB, mb, force_b, tk && at_b, m_dn);
      if (sq < 2) begin
         if (cmpa_wr) begin m_actA = cmpa_wdata; m_bufA = cmpa_wdata; end
         if (cmpb_wr) begin m_actB = cmpb_wdata; m_bufB = cmpb_wdata; end
      end else begin
         nA = upd ? m_bufA : m_actA;
         nB = upd ? m_bufB : m_actB;
         if (cmpa_wr) m_bufA = cmpa_wdata;
         if (cmpb_wr) m_bufB = cmpb_wdata;
         m_actA = nA; m_actB = nB;
      end
      m_fA = ma  || (m_fA && !flag_clr[0]);
      m_fB = mb  || (m_fB && !flag_clr[1]);
      m_fO = ovf || (m_fO && !flag_clr[2]);
      if (cnt_wr) begin
         m_cnt = cnt_wdata;
      end else if (tk) begin
         if (sq != 3) begin
            m_cnt = at_t ? 0 : (m_cnt + 1) % 256;
            m_dn  = 0;
         end else if (m_dn == 0) begin
            if (at_t) begin
               if (!at_b) begin m_cnt = m_cnt - 1; m_dn = 1; end
            end else begin
               m_cnt = (m_cnt + 1) % 256;
            end
         end else if (at_b) begin
            m_cnt = at_t ? 0 : 1;
            m_dn  = 0;
         end else begin
            m_cnt = m_cnt - 1;
         end
      end
      m_sup = cnt_wr;
   endtask

   always @(posedge clk) begin
      int sq;
      model_step();
      #1;
      if (rst_n && !done) begin
         sq = seq_of(mode);
         check(cur_req, "count", count, m_cnt);
         check(cur_req, "wave_a", wave_a, wave_exp(sq, outmode_a, m_pinA));
         check(cur_req, "wave_b", wave_b, wave_exp(sq, outmode_b, m_pinB));
         check("R11", "flag_cmpa", flag_cmpa, m_fA);
         check("R11", "flag_cmpb", flag_cmpb, m_fB);
         check(cur_req, "flag_ovf", flag_ovf, m_fO);
      end
   end

   task automatic run(int n, int div);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = ((i % div) == 0);
      end
   endtask

   task automatic wr_cnt(int v);
      @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 8'(v);
      @(negedge clk); cnt_wr = 1'b0;
   endtask

   task automatic wr_cmp(int a, int b);
      @(negedge clk);
      cmpa_wr = 1'b1; cmpa_wdata = 8'(a);
      cmpb_wr = 1'b1; cmpb_wdata = 8'(b);
      @(negedge clk); cmpa_wr = 1'b0; cmpb_wr = 1'b0;
   endtask

   task automatic clr_flags(int bits);
      @(negedge clk); flag_clr = 3'(bits);
      @(negedge clk); flag_clr = '0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         done = 1'b1;
         summary();
         $finish;
      end
   end

   initial begin
      int w0;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "count", count, 0);
      check("R1", "wave_a", wave_a, 0);
      check("R1", "flags", {flag_cmpa, flag_cmpb, flag_ovf}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "count after release", count, 0);

      // R2 R5 R6: normal mode, toggle A, set B, full wraps
      cur_req = "R2";
      outmode_a = 2'b01; outmode_b = 2'b11;
      wr_cmp(8'h10, 8'h20);
      run(600, 1);
      clr_flags(7);
      run(50, 1);

      // R11: clear issued on the same cycle as a match on A
      cur_req = "R11";
      tick = 1'b0;
      wr_cnt(8'h0F);
      clr_flags(7);
      @(negedge clk); tick = 1'b1; flag_clr = 3'b001;   // count 0x0F, no match
      @(negedge clk); flag_clr = 3'b001;                // count 0x10 matches A while clearing
      @(negedge clk); flag_clr = '0; tick = 1'b0;
      @(posedge clk); #1;
      check("R11", "set beats clear", flag_cmpa, 1);

      // R9: force strobes in normal mode, no flag
      cur_req = "R9";
      clr_flags(7);
      @(posedge clk); #1;
      w0 = wave_a;
      @(negedge clk); force_a = 1'b1;
      @(negedge clk); force_a = 1'b0;
      @(posedge clk); #1;
      check("R9", "forced toggle", wave_a, 1 - w0);
      check("R9", "no flag from force", flag_cmpa, 0);
      outmode_b = 2'b10;
      @(negedge clk); force_b = 1'b1;
      @(negedge clk); force_b = 1'b0;
      @(posedge clk); #1;
      check("R9", "forced clear", wave_b, 0);

      // R10: counter write onto the compare value masks the match
      cur_req = "R10";
      wr_cmp(8'h40, 8'h80);
      clr_flags(7);
      @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 8'h40; tick = 1'b1;
      @(negedge clk); cnt_wr = 1'b0;
      @(negedge clk); tick = 1'b0;
      @(posedge clk); #1;
      check("R10", "masked match", flag_cmpa, 0);
      check("R10", "count advanced", count, 8'h41);

      // R12: sparse ticks and writes alongside ticks
      cur_req = "R12";
      run(90, 3);
      @(negedge clk); tick = 1'b1; cnt_wr = 1'b1; cnt_wdata = 8'hF0;
      @(negedge clk); cnt_wr = 1'b0; tick = 1'b0;
      @(posedge clk); #1;
      check("R12", "write over tick", count, 8'hF0);
      run(60, 2);

      // R2: clear-on-compare and a reserved code
      cur_req = "R2";
      wr_cnt(0);
      mode = 3'b010; outmode_a = 2'b01;
      wr_cmp(5, 3);
      run(60, 1);
      mode = 3'b100;
      wr_cnt(0);
      run(300, 1);

      // R7 R4: fast PWM, TOP 0xFF, buffered compare updates
      cur_req = "R7";
      mode = 3'b011; outmode_a = 2'b10; outmode_b = 2'b11;
      wr_cnt(0);
      wr_cmp(8'h30, 8'hC0);
      run(300, 1);
      cur_req = "R4";
      wr_cmp(8'h80, 8'h00);
      run(600, 1);

      // R5: fast PWM with TOP from compare A
      cur_req = "R5";
      mode = 3'b111;
      wr_cnt(0);
      wr_cmp(50, 20);
      run(300, 1);

      // R3 R8: phase-correct with TOP 0xFF then TOP from A
      cur_req = "R3";
      mode = 3'b001; outmode_a = 2'b10; outmode_b = 2'b11;
      wr_cnt(0);
      wr_cmp(8'h40, 8'hA0);
      run(1100, 1);
      cur_req = "R8";
      mode = 3'b101;
      wr_cnt(0);
      wr_cmp(60, 25);
      run(200, 1);
      wr_cmp(40, 10);
      run(300, 2);

      // R6: remaining non-PWM actions
      cur_req = "R6";
      mode = 3'b000; outmode_a = 2'b00; outmode_b = 2'b10;
      wr_cnt(0);
      run(300, 1);

      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule